// File: doc/BRIEF.md
# SAR converter control sequencer

This block is the digital half of a 12-bit successive-approximation converter that sits behind an eight-input analog multiplexer. Software writes one control byte. The byte picks the input channel, the span, the polarity and the power behaviour. The write starts an internally timed acquisition window. The block then resolves the result one bit per clock against an external comparator and publishes the finished code as a low byte and a high byte. The sample/hold, the DAC and the comparator are outside the block. The block drives the trial DAC code out and takes the comparator decision back in.

A new control byte always wins. If it arrives while the block is waking, acquiring or converting, the work in progress is thrown away and the sequence starts again. A power-down request carried in the byte is deferred until the requested conversion has finished. The published result stays readable in either low-power state. The states are `ST_IDLE`, `ST_WAKE`, `ST_ACQ`, `ST_CONV`, `ST_STBY` and `ST_FULL`. The transitions are as follows:
- A write moves any state to `ST_ACQ`, except that a write in `ST_FULL` or `ST_WAKE` moves to `ST_WAKE`.
- `ST_WAKE` moves to `ST_ACQ` after `WAKE_CYC` cycles.
- `ST_ACQ` moves to `ST_CONV` after `ACQ_CYC` cycles.
- `ST_CONV` moves, after the last bit, to `ST_STBY`, `ST_FULL` or `ST_IDLE` according to the power field.
- `ST_IDLE`, `ST_STBY` and `ST_FULL` hold until the next write.

Top module: `sarctl_top`

## Requirements
- R1: After reset, busy, track, pd_stby and pd_full are 0, dac_code is 0, and res_lo and res_hi are 0.
- R2: ctl_byte is sampled on a clock edge where ctl_wr is 1. From the next cycle onward, mux_chan shows bits 2:0 of the byte, bipolar shows bit 3 and span_hi shows bit 4. Bit 5, the acquisition-source bit, changes neither the timing nor the result.
- R3: track is 1 for exactly ACQ_CYC (6) cycles. These cycles start in the cycle after the accepting edge when the block is not in full power-down.
- R4: The approximation runs for RES_W (12) cycles, from the MSB down to the LSB. In the cycle that tries bit i, dac_code is the bits already kept plus bit i. Bit i is kept when cmp_in is 1, where 1 means the input is at or above dac_code. Outside conversion dac_code is 0.
- R5: busy rises in the cycle after the accepting edge. It falls on the same edge that loads the result, which is ACQ_CYC+RES_W (18) edges after the write when no wake wait applies.
- R6: A write while waking, acquiring or converting restarts the sequence. busy stays 1 throughout, and the aborted conversion never changes the result.
- R7: With bit 3 = 0, the result is the straight-binary code the comparator resolves, from 000h to FFFh.
- R8: With bit 3 = 1, the result is two's complement: the resolved code with its MSB inverted. Resolved 000h (minus full scale) gives 800h, and resolved 800h (mid-scale) gives 000h.
- R9: res_lo holds result bits 7:0. res_hi holds bits 11:8 in its bits 3:0, and its bits 7:4 are all 0 for a unipolar result and all 1 for a bipolar one. The fill follows the conversion that produced the result, not a later write.
- R10: Power field (bits 7:6) 10 selects standby and 11 selects full power-down. pd_stby or pd_full goes to 1 only on the edge that loads the result, and both stay 0 while busy.
- R11: A write in standby starts acquisition at once. A write in full power-down first holds busy=1, track=0 for WAKE_CYC (20) cycles and then acquires. A write during that wait restarts the wait.
- R12: res_lo and res_hi stay unchanged while in either power-down state.
- R13: Power field values 00 and 01 both return to idle after the conversion, with pd_stby and pd_full at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control byte write strobe, one cycle |
| ctl_byte | input | 8 | Control byte |
| cmp_in | input | 1 | Comparator decision, 1 = input at or above dac_code |
| dac_code | output | RES_W | Trial code for the DAC |
| mux_chan | output | 3 | Selected multiplexer input |
| span_hi | output | 1 | 1 = wide span selected |
| bipolar | output | 1 | 1 = bipolar input range selected |
| track | output | 1 | Sample/hold tracking window |
| busy | output | 1 | Conversion pending |
| pd_stby | output | 1 | Standby power-down active |
| pd_full | output | 1 | Full power-down active |
| res_lo | output | 8 | Result bits 7:0 |
| res_hi | output | 8 | Result bits 11:8 plus polarity fill |

## Verification
The properties assume that ctl_wr is a clean one-cycle strobe that is low during reset, and that cmp_in settles within the cycle from the dac_code it is answering. The bench models the comparator as a combinational compare of dac_code against a held input code, so the second assumption holds by construction. Writes are driven on falling edges and last exactly one cycle. The random input codes are changed only between conversions or at an abort, which keeps every resolved code equal to a defined input level.

// File: rtl/sarctl_pkg.sv
`timescale 1ns/1ps
package sarctl_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_ACQ,
        ST_CONV,
        ST_STBY,
        ST_FULL
    } sar_state_e;

    // Power field of the control byte
    typedef enum logic [1:0] {
        PM_EXTCLK = 2'b00,
        PM_INTCLK = 2'b01,
        PM_STBY   = 2'b10,
        PM_FULL   = 2'b11
    } pwr_mode_e;

    // Control byte, most significant field first
    typedef struct packed {
        pwr_mode_e   pmode;    // bits 7:6
        logic        acq_ext;  // bit 5, treated as internal acquisition
        logic        span_hi;  // bit 4
        logic        bip;      // bit 3
        logic [2:0]  chan;     // bits 2:0
    } ctl_word_t;

endpackage

// File: rtl/sarctl_ctlreg.sv
`timescale 1ns/1ps
module sarctl_ctlreg
    import sarctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    output ctl_word_t  ctl_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_en) begin
            ctl_q <= ctl_word_t'(wr_byte);
        end
    end

endmodule

// File: rtl/sarctl_fsm.sv
`timescale 1ns/1ps
module sarctl_fsm
    import sarctl_pkg::*;
#(
    parameter int RES_W    = 12,
    parameter int ACQ_CYC  = 6,
    parameter int WAKE_CYC = 20,
    localparam int CNT_MAX = (ACQ_CYC > WAKE_CYC) ? ACQ_CYC : WAKE_CYC,
    localparam int CNT_W   = $clog2(CNT_MAX + 1),
    localparam int BIT_W   = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  pwr_mode_e        pmode,
    output logic [BIT_W-1:0] bit_idx,
    output logic             busy,
    output logic             track,
    output logic             converting,
    output logic             conv_done,
    output logic             pd_stby,
    output logic             pd_full
);

    localparam logic [BIT_W-1:0] TOP_BIT  = BIT_W'(RES_W - 1);
    localparam logic [CNT_W-1:0] ACQ_LAST = CNT_W'(ACQ_CYC - 1);
    localparam logic [CNT_W-1:0] WAK_LAST = CNT_W'(WAKE_CYC - 1);
    localparam bit               HAS_WAKE = (WAKE_CYC > 0);

    sar_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [BIT_W-1:0] bit_q, bit_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        bit_d   = bit_q;
        if (wr_en) begin
            // a new control byte aborts whatever is in progress
            cnt_d = '0;
            bit_d = TOP_BIT;
            if (HAS_WAKE && (state_q == ST_FULL || state_q == ST_WAKE)) begin
                state_d = ST_WAKE;
            end else begin
                state_d = ST_ACQ;
            end
        end else begin
            unique case (state_q)
                ST_IDLE, ST_STBY, ST_FULL: begin
                    state_d = state_q;
                end
                ST_WAKE: begin
                    if (cnt_q == WAK_LAST) begin
                        state_d = ST_ACQ;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_ACQ: begin
                    if (cnt_q == ACQ_LAST) begin
                        state_d = ST_CONV;
                        cnt_d   = '0;
                        bit_d   = TOP_BIT;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_CONV: begin
                    if (bit_q == '0) begin
                        // deferred power-down takes effect here
                        unique case (pmode)
                            PM_STBY:            state_d = ST_STBY;
                            PM_FULL:            state_d = ST_FULL;
                            PM_EXTCLK, PM_INTCLK: state_d = ST_IDLE;
                            default:            state_d = ST_IDLE;
                        endcase
                    end else begin
                        bit_d = bit_q - 1'b1;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bit_q   <= TOP_BIT;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bit_q   <= bit_d;
        end
    end

    // Outputs
    always_comb begin
        bit_idx    = bit_q;
        busy       = (state_q == ST_WAKE) || (state_q == ST_ACQ) || (state_q == ST_CONV);
        track      = (state_q == ST_ACQ);
        converting = (state_q == ST_CONV);
        conv_done  = (state_q == ST_CONV) && (bit_q == '0) && !wr_en;
        pd_stby    = (state_q == ST_STBY);
        pd_full    = (state_q == ST_FULL);
    end

endmodule

// File: rtl/sarctl_sar.sv
`timescale 1ns/1ps
module sarctl_sar #(
    parameter int RES_W = 12,
    localparam int BIT_W = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             active,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] next_code
);

    logic [RES_W-1:0] sar_q;
    logic [RES_W-1:0] trial;

    always_comb begin
        trial     = sar_q | (RES_W'(1) << bit_idx);
        next_code = cmp_in ? trial : sar_q;
        dac_code  = active ? trial : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sar_q <= '0;
        end else if (clear) begin
            sar_q <= '0;
        end else if (active) begin
            sar_q <= next_code;
        end
    end

endmodule

// File: rtl/sarctl_result.sv
`timescale 1ns/1ps
module sarctl_result #(
    parameter int RES_W = 12,
    localparam int FILL_W = 16 - RES_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             bip_in,
    input  logic [RES_W-1:0] code,
    output logic [7:0]       res_lo,
    output logic [7:0]       res_hi
);

    localparam logic [RES_W-1:0] MSB_MASK = RES_W'(1) << (RES_W - 1);

    logic [RES_W-1:0] res_q;
    logic             fill_q;
    logic [RES_W-1:0] formatted;

    // offset binary to two's complement for bipolar spans
    always_comb begin
        formatted = bip_in ? (code ^ MSB_MASK) : code;
    end

    // code and fill polarity update together
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= '0;
            fill_q <= 1'b0;
        end else if (load) begin
            res_q  <= formatted;
            fill_q <= bip_in;
        end
    end

    generate
        if (FILL_W > 0) begin : g_fill
            assign res_hi = {{FILL_W{fill_q}}, res_q[RES_W-1:8]};
        end else begin : g_nofill
            assign res_hi = res_q[15:8];
        end
    endgenerate

    assign res_lo = res_q[7:0];

endmodule

// File: rtl/sarctl_top.sv
`timescale 1ns/1ps
module sarctl_top
    import sarctl_pkg::*;
#(
    parameter int RES_W    = 12,
    parameter int ACQ_CYC  = 6,
    parameter int WAKE_CYC = 20,
    localparam int BIT_W   = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_byte,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic [2:0]       mux_chan,
    output logic             span_hi,
    output logic             bipolar,
    output logic             track,
    output logic             busy,
    output logic             pd_stby,
    output logic             pd_full,
    output logic [7:0]       res_lo,
    output logic [7:0]       res_hi
);

    ctl_word_t        ctl_q;
    logic [BIT_W-1:0] bit_idx;
    logic             converting;
    logic             conv_done;
    logic [RES_W-1:0] next_code;

    sarctl_ctlreg u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr),
        .wr_byte (ctl_byte),
        .ctl_q   (ctl_q)
    );

    sarctl_fsm #(
        .RES_W    (RES_W),
        .ACQ_CYC  (ACQ_CYC),
        .WAKE_CYC (WAKE_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ctl_wr),
        .pmode      (ctl_q.pmode),
        .bit_idx    (bit_idx),
        .busy       (busy),
        .track      (track),
        .converting (converting),
        .conv_done  (conv_done),
        .pd_stby    (pd_stby),
        .pd_full    (pd_full)
    );

    sarctl_sar #(
        .RES_W (RES_W)
    ) u_sar (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (track),
        .active    (converting),
        .bit_idx   (bit_idx),
        .cmp_in    (cmp_in),
        .dac_code  (dac_code),
        .next_code (next_code)
    );

    sarctl_result #(
        .RES_W (RES_W)
    ) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (conv_done),
        .bip_in (ctl_q.bip),
        .code   (next_code),
        .res_lo (res_lo),
        .res_hi (res_hi)
    );

    assign mux_chan = ctl_q.chan;
    assign span_hi  = ctl_q.span_hi;
    assign bipolar  = ctl_q.bip;

endmodule

// File: rtl/sarctl_chk.sv
`timescale 1ns/1ps
module sarctl_chk #(
    parameter int RES_W    = 12,
    parameter int WAKE_CYC = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic [7:0]       ctl_byte,
    input logic [7:0]       ctl_word,
    input logic [RES_W-1:0] dac_code,
    input logic [2:0]       mux_chan,
    input logic             track,
    input logic             busy,
    input logic             pd_stby,
    input logic             pd_full,
    input logic [7:0]       res_lo,
    input logic [7:0]       res_hi
);

    // R2
    ctl_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (ctl_word == $past(ctl_byte)) && (mux_chan == $past(ctl_byte[2:0])));

    // R3
    track_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        track |-> busy);

    // R4
    dac_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || track) |-> (dac_code == '0));

    // R5
    write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> busy);

    // R6
    res_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable({res_lo, res_hi}));

    // R10
    pd_after_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_stby || pd_full) |-> (!busy && !(pd_stby && pd_full)));

    // R11
    stby_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && pd_stby) |=> track);

    // R11
    full_exit_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && pd_full && (WAKE_CYC > 0)) |=> (busy && !track));

    // R12
    pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pd_stby || pd_full) && !ctl_wr) |=> $stable({res_lo, res_hi}));

endmodule

bind sarctl_top sarctl_chk #(
    .RES_W    (RES_W),
    .WAKE_CYC (WAKE_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .ctl_byte (ctl_byte),
    .ctl_word (ctl_q),
    .dac_code (dac_code),
    .mux_chan (mux_chan),
    .track    (track),
    .busy     (busy),
    .pd_stby  (pd_stby),
    .pd_full  (pd_full),
    .res_lo   (res_lo),
    .res_hi   (res_hi)
);

// File: tb/sarctl_top_test.sv
`timescale 1ns/1ps
module sarctl_top_test;

    localparam int RES_W    = 12;
    localparam int ACQ_CYC  = 6;
    localparam int WAKE_CYC = 20;
    localparam int CONV_LEN = ACQ_CYC + RES_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_byte = 8'h00;
    logic [11:0] vin = 12'h000;
    logic        cmp_in;
    logic [11:0] dac_code;
    logic [2:0]  mux_chan;
    logic        span_hi, bipolar, track, busy, pd_stby, pd_full;
    logic [7:0]  res_lo, res_hi;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    // comparator model: input at or above the trial code
    assign cmp_in = (dac_code <= vin);

    sarctl_top #(
        .RES_W (RES_W), .ACQ_CYC (ACQ_CYC), .WAKE_CYC (WAKE_CYC)
    ) uut (
        .clk (clk), .rst_n (rst_n), .ctl_wr (ctl_wr), .ctl_byte (ctl_byte),
        .cmp_in (cmp_in), .dac_code (dac_code), .mux_chan (mux_chan),
        .span_hi (span_hi), .bipolar (bipolar), .track (track), .busy (busy),
        .pd_stby (pd_stby), .pd_full (pd_full), .res_lo (res_lo), .res_hi (res_hi)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_code(input logic [11:0] v, input bit bip);
        return bip ? (v ^ 12'h800) : v;
    endfunction

    function automatic logic [7:0] exp_hi(input logic [11:0] v, input bit bip);
        logic [11:0] c;
        c = exp_code(v, bip);
        return {{4{bip}}, c[11:8]};
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ends on the falling edge right after the accepting edge (call it n0)
    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        ctl_wr   = 1'b1;
        ctl_byte = b;
        @(negedge clk);
        ctl_wr   = 1'b0;
    endtask

    // full conversion without wake wait; checks end timing and result
    task automatic conv(input logic [7:0] b, input logic [11:0] v, input string tag);
        vin = v;
        wr(b);
        step(CONV_LEN - 1);
        chk({"R5 busy before end ", tag}, busy, 1);
        step(1);
        chk({"R5 busy after end ", tag}, busy, 0);
        chk({"R7 R8 res_lo ", tag}, res_lo, exp_code(v, b[3]) & 12'h0FF);
        chk({"R9 res_hi ", tag}, res_hi, exp_hi(v, b[3]));
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        logic [7:0] prev_lo, prev_hi;
        void'($urandom(32'd20240611));

        step(3);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 track", track, 0);
        chk("R1 dac", dac_code, 0);
        chk("R1 lo", res_lo, 0);
        chk("R1 hi", res_hi, 0);
        chk("R1 pd", {pd_stby, pd_full}, 0);
        rst_n = 1'b1;
        step(2);

        // R3 R4 detailed walk, unipolar, channel 5
        vin = 12'hABC;
        wr(8'h45);
        chk("R2 chan", mux_chan, 5);
        for (int j = 0; j < ACQ_CYC; j++) begin
            chk("R3 track window", track, 1);
            chk("R4 dac during track", dac_code, 0);
            step(1);
        end
        chk("R3 track end", track, 0);
        for (int j = 0; j < RES_W; j++) begin
            int bi;
            logic [11:0] above;
            bi = RES_W - 1 - j;
            above = (12'h1 << (bi + 1)) - 12'h1;
            chk("R4 trial code", dac_code, (vin & ~above) | (12'h1 << bi));
            chk("R5 busy in conv", busy, 1);
            step(1);
        end
        chk("R5 busy falls", busy, 0);
        chk("R7 lo", res_lo, 8'hBC);
        chk("R9 hi", res_hi, 8'h0A);
        chk("R4 dac idle", dac_code, 0);

        // R7 R8 R9 corner codes
        conv(8'h40, 12'h000, "uni zero");
        conv(8'h50, 12'hFFF, "uni full");
        conv(8'h48, 12'h000, "R8 bip minus fs");
        chk("R8 minus fs hi", res_hi, 8'hF8);
        conv(8'h58, 12'h800, "R8 bip zero");
        chk("R8 zero lo", res_lo, 8'h00);
        conv(8'h48, 12'hFFF, "R8 bip plus fs");
        chk("R8 plus fs hi", res_hi, 8'hF7);

        // R2 acquisition-source bit has no effect
        conv(8'h63, 12'h123, "R2 acq bit");
        chk("R2 span", span_hi, 0);
        chk("R2 chan acq", mux_chan, 3);

        // R9 fill belongs to the stored result
        conv(8'h4E, 12'h200, "R9 bip before");
        prev_hi = res_hi;
        vin = 12'h155;
        wr(8'h41);
        step(5);
        chk("R9 fill kept during next conv", res_hi, prev_hi);
        step(CONV_LEN - 5);
        chk("R9 unipolar fill", res_hi, 8'h01);
        chk("R9 lo", res_lo, 8'h55);

        // R6 abort during conversion
        prev_lo = res_lo;
        prev_hi = res_hi;
        vin = 12'h3C3;
        wr(8'h40);
        step(10);
        vin = 12'h0F0;
        wr(8'h42);
        chk("R6 busy held", busy, 1);
        chk("R6 chan updated", mux_chan, 2);
        step(CONV_LEN - 1);
        chk("R6 busy restarted", busy, 1);
        chk("R6 result untouched", {res_hi, res_lo}, {prev_hi, prev_lo});
        step(1);
        chk("R6 busy end", busy, 0);
        chk("R6 new lo", res_lo, 8'hF0);
        chk("R6 new hi", res_hi, 8'h00);

        // R6 abort during acquisition
        vin = 12'h9A9;
        wr(8'h40);
        step(2);
        wr(8'h47);
        step(CONV_LEN - 1);
        chk("R6 acq abort busy", busy, 1);
        step(1);
        chk("R6 acq abort done", busy, 0);
        chk("R6 acq abort lo", res_lo, 8'hA9);

        // R10 R12 R11 standby
        vin = 12'h5A5;
        wr(8'h84);
        step(10);
        chk("R10 stby deferred", pd_stby, 0);
        step(CONV_LEN - 10);
        chk("R10 stby on", pd_stby, 1);
        chk("R10 stby busy", busy, 0);
        chk("R12 stby lo", res_lo, 8'hA5);
        step(30);
        chk("R12 stby hold", {res_hi, res_lo}, 16'h05A5);
        vin = 12'h321;
        wr(8'h41);
        chk("R11 stby exit track", track, 1);
        chk("R11 stby exit pd", pd_stby, 0);
        step(CONV_LEN);
        chk("R11 stby exit done", busy, 0);
        chk("R11 stby exit lo", res_lo, 8'h21);

        // R10 R12 R11 full power-down
        vin = 12'h777;
        wr(8'hC0);
        step(CONV_LEN);
        chk("R10 full on", pd_full, 1);
        chk("R10 full excl", pd_stby, 0);
        step(10);
        chk("R12 full hold", {res_hi, res_lo}, 16'h0777);
        vin = 12'h246;
        wr(8'h40);
        chk("R11 wake busy", busy, 1);
        chk("R11 wake no track", track, 0);
        chk("R11 wake pd off", pd_full, 0);
        step(WAKE_CYC - 1);
        chk("R11 wake last", track, 0);
        step(1);
        chk("R11 acq after wake", track, 1);
        step(CONV_LEN - 1);
        chk("R11 busy pre", busy, 1);
        step(1);
        chk("R11 busy after wake conv", busy, 0);
        chk("R11 lo after wake", res_lo, 8'h46);

        // R11 write during wake restarts the wait
        wr(8'hC0);
        step(CONV_LEN);
        wr(8'h40);
        step(10);
        wr(8'h41);
        step(WAKE_CYC - 1);
        chk("R11 restarted wait", track, 0);
        step(1);
        chk("R11 restarted acq", track, 1);
        step(CONV_LEN);
        chk("R11 restarted done", busy, 0);

        // R13 normal power codes
        conv(8'h00, 12'h0AA, "R13 code00");
        chk("R13 code00 pd", {pd_stby, pd_full}, 0);
        conv(8'h40, 12'h0BB, "R13 code01");
        chk("R13 code01 pd", {pd_stby, pd_full}, 0);

        // random mix, normal power codes
        for (int i = 0; i < 40; i++) begin
            logic [7:0]  b;
            logic [11:0] v;
            b = (8'($urandom) & 8'h3F) | (($urandom % 2 == 0) ? 8'h40 : 8'h00);
            v = 12'($urandom);
            conv(b, v, "random");
            chk("R2 random chan", mux_chan, b[2:0]);
            chk("R2 random bip", bipolar, b[3]);
            chk("R2 random span", span_hi, b[4]);
        end

        summary();
    end

endmodule